// File: doc/BRIEF.md
# Masked Capability Register Bank

This block holds a small bank of 32-bit capability and control registers for a coherent-memory link component. The registers sit behind a memory-mapped request port with one request per cycle. Each register carries a fixed per-bit write mask. A write changes only the bits the mask allows, and every other bit keeps its stored value. Registers that are entirely read-only return constants.

At reset the bank builds a chain of capability headers. A component-type strap, sampled only while reset is high, sets how many capability structures the chain lists. Those structures are error reporting (RAS), link, a memory-range decoder block, extended security and snoop. The bank holds the RAS mask and severity registers. It also holds the decoder block: one capability word, a global control word and a parameterised number of decoders, each with base, size and control words.

Accesses must be 4 bytes wide and word aligned to take effect. An 8-byte access, an unaligned access, or an access to an offset that holds nothing reads as zero and never changes state.

Top module: `cmreg_bank`

## Requirements
- R1: A legal write stores (wdata & mask) | (old & ~mask) into the addressed register. Bits outside the mask never change, and a register with a zero mask (RAS status words at 0x040 and 0x04C, RAS capability control at 0x054, decoder capability at 0x100) always reads its constant.
- R2: After reset the RAS words read as follows: uncorrectable mask (0x044) is 0x0001CFFF, uncorrectable severity (0x048) is 0x0001CFFF, correctable mask (0x050) is 0x0000007F, and 0x040, 0x04C and 0x054 are 0. The write masks are 0x0001CFFF, 0x0001CFFF and 0x0000007F.
- R3: Word 0x000 reads {count[7:0], 4'h1, 4'h1, 16'h0001}. The fields are count in bits 31:24, cache/mem version in 23:20, version in 19:16 and ID in 15:0.
- R4: The count comes from comp_type: codes 0 and 1 give 2, codes 2, 3 and 4 give 3, code 5 gives 5, and codes 6 and 7 give 2. comp_type is sampled only in cycles where rst is high, and later changes have no effect.
- R5: Word 0x004+4*k (k < count) reads {pointer[11:0], version[3:0], ID[15:0]}, with the pointer in bits 31:20 and the ID in 15:0. The entries are, in order: (0x040,2,2), (0x080,2,4), (0x100,1,5), (0x180,1,6), (0x1C0,1,8). Entries with k >= count read 0.
- R6: The decoder block (0x100–0x17F) exists only when count >= 3. In that case 0x100 reads 0x00000310 and the global control word (0x104) resets to 0 with write mask 0x3. When the block is absent it reads 0 and writes to it are ignored.
- R7: Decoder i occupies 0x110+0x20*i. Its words are base low (+0x0, mask 0xF0000000), base high (+0x4, mask 0xFFFFFFFF), size low (+0x8, mask 0xF0000000), size high (+0xC, mask 0xFFFFFFFF) and control (+0x10, mask 0x000013FF). All reset to 0.
- R8: An 8-byte access (req_size=1) reads 0 and a write of that size changes nothing.
- R9: An access with req_addr[1:0] != 0 reads 0 and a write to such an address changes nothing.
- R10: An offset that holds no register reads 0, and a write to it changes nothing.
- R11: A read request accepted in cycle n raises rsp_valid, with its data on rsp_rdata, in cycle n+1 only. A write request gives no response.
- R12: Reset is synchronous and wins over a write presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_type | input | 3 | Component-type strap, sampled during reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = 4-byte access, 1 = 8-byte access |
| req_addr | input | 9 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |

## Verification
Two of the block's functions can meet in one cycle: the synchronous reload of reset values and a write request. The bench raises rst in the same cycle that it presents a write of zero to the uncorrectable mask. It then reads the word back, and only the reset value 0x0001CFFF passes. The same idea applies to masked merging of read-only and writable bits within one word. Each write that sets all ones must read back exactly the mask, and a later strap change must leave the header count as it was captured.

// File: rtl/cmreg_pkg.sv
package cmreg_pkg;
  localparam int DW     = 32;
  localparam int ADDR_W = 9;
  localparam int NCAP   = 5;

  localparam logic [11:0] RAS_BASE  = 12'h040;
  localparam logic [11:0] LINK_BASE = 12'h080;
  localparam logic [11:0] HDM_BASE  = 12'h100;
  localparam logic [11:0] XSEC_BASE = 12'h180;
  localparam logic [11:0] SNP_BASE  = 12'h1C0;

  localparam logic [DW-1:0] UNC_MASK_W = 32'h0001_CFFF;
  localparam logic [DW-1:0] COR_MASK_W = 32'h0000_007F;
  localparam logic [DW-1:0] GCTL_W     = 32'h0000_0003;

  localparam int DEC_WORDS = 5;

  function automatic logic [2:0] caps_of(input logic [2:0] t);
    case (t)
      3'd2, 3'd3, 3'd4: caps_of = 3'd3;
      3'd5:             caps_of = 3'd5;
      default:          caps_of = 3'd2;
    endcase
  endfunction

  function automatic logic [DW-1:0] cap_hdr(input logic [2:0] k);
    case (k)
      3'd0:    cap_hdr = {RAS_BASE,  4'd2, 16'd2};
      3'd1:    cap_hdr = {LINK_BASE, 4'd2, 16'd4};
      3'd2:    cap_hdr = {HDM_BASE,  4'd1, 16'd5};
      3'd3:    cap_hdr = {XSEC_BASE, 4'd1, 16'd6};
      3'd4:    cap_hdr = {SNP_BASE,  4'd1, 16'd8};
      default: cap_hdr = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] dec_mask(input int j);
    case (j)
      0, 2:    dec_mask = 32'hF000_0000;
      1, 3:    dec_mask = 32'hFFFF_FFFF;
      default: dec_mask = 32'h0000_13FF;
    endcase
  endfunction

  function automatic logic [3:0] dec_cnt_enc(input int n);
    dec_cnt_enc = (n <= 1) ? 4'd0 : 4'($clog2(n));
  endfunction
endpackage

// File: rtl/cmreg_mreg.sv
module cmreg_mreg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] WMASK   = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else if (we) q <= (wdata & WMASK) | (q & ~WMASK);
  end

  // R1: bits outside the mask never move
  p_ro_bits_r1: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q & ~WMASK) == ($past(q) & ~WMASK)));
  // R1: no write, no change
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/cmreg_hdr.sv
module cmreg_hdr
  import cmreg_pkg::*;
(
  input  logic [2:0]    caps,
  input  logic [3:0]    idx,
  output logic [DW-1:0] rdata
);
  logic [2:0] k;
  assign k = 3'(idx - 4'd1);

  always_comb begin
    rdata = '0;
    if (idx == 4'd0)
      rdata = {5'd0, caps, 4'h1, 4'h1, 16'h0001};
    else if (idx <= {1'b0, caps})
      rdata = cap_hdr(k);
  end
endmodule

// File: rtl/cmreg_ras.sv
module cmreg_ras
  import cmreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [3:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam logic [3:0] OFF_UMASK = 4'd1;
  localparam logic [3:0] OFF_USEV  = 4'd2;
  localparam logic [3:0] OFF_CMASK = 4'd4;

  logic [DW-1:0] umask_q, usev_q, cmask_q;

  cmreg_mreg #(.W(DW), .RST_VAL(UNC_MASK_W), .WMASK(UNC_MASK_W)) u_umask (
    .clk(clk), .rst(rst), .we(we && off == OFF_UMASK), .wdata(wdata), .q(umask_q));
  cmreg_mreg #(.W(DW), .RST_VAL(UNC_MASK_W), .WMASK(UNC_MASK_W)) u_usev (
    .clk(clk), .rst(rst), .we(we && off == OFF_USEV), .wdata(wdata), .q(usev_q));
  cmreg_mreg #(.W(DW), .RST_VAL(COR_MASK_W), .WMASK(COR_MASK_W)) u_cmask (
    .clk(clk), .rst(rst), .we(we && off == OFF_CMASK), .wdata(wdata), .q(cmask_q));

  always_comb begin
    rdata = '0;
    if (off == OFF_UMASK)      rdata = umask_q;
    else if (off == OFF_USEV)  rdata = usev_q;
    else if (off == OFF_CMASK) rdata = cmask_q;
  end
endmodule

// File: rtl/cmreg_hdm.sv
module cmreg_hdm
  import cmreg_pkg::*;
#(
  parameter int NUM_DEC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          present,
  input  logic          we,
  input  logic [4:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int OFF_W      = 5;
  localparam int DEC_FIRST  = 4;
  localparam int DEC_STRIDE = 8;
  localparam logic [DW-1:0] CAP_WORD =
    {21'd0, 1'b0, 1'b1, 1'b1, 4'd1, dec_cnt_enc(NUM_DEC)};

  logic          wen;
  logic [DW-1:0] gctl_q;
  logic [NUM_DEC-1:0][DEC_WORDS-1:0][DW-1:0] dq;

  assign wen = we && present;

  cmreg_mreg #(.W(DW), .RST_VAL('0), .WMASK(GCTL_W)) u_gctl (
    .clk(clk), .rst(rst), .we(wen && off == OFF_W'(1)), .wdata(wdata), .q(gctl_q));

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    for (genvar j = 0; j < DEC_WORDS; j++) begin : g_word
      cmreg_mreg #(.W(DW), .RST_VAL('0), .WMASK(dec_mask(j))) u_reg (
        .clk(clk), .rst(rst),
        .we(wen && off == OFF_W'(DEC_FIRST + DEC_STRIDE * i + j)),
        .wdata(wdata), .q(dq[i][j]));
    end
  end

  always_comb begin
    rdata = '0;
    if (present) begin
      if (off == OFF_W'(0)) rdata = CAP_WORD;
      if (off == OFF_W'(1)) rdata = gctl_q;
      for (int i = 0; i < NUM_DEC; i++)
        for (int j = 0; j < DEC_WORDS; j++)
          if (off == OFF_W'(DEC_FIRST + DEC_STRIDE * i + j)) rdata = dq[i][j];
    end
  end
endmodule

// File: rtl/cmreg_bank.sv
module cmreg_bank
  import cmreg_pkg::*;
#(
  parameter int NUM_DEC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        comp_type,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  logic [2:0]    caps_q;
  logic          legal, acc_wr, is_rd;
  logic          in_hdr, in_ras, in_hdm, hdm_present;
  logic [DW-1:0] hdr_rd, ras_rd, hdm_rd, rd_mux;

  assign legal       = !req_size && (req_addr[1:0] == 2'b00);
  assign acc_wr      = req_valid && req_write && legal;
  assign is_rd       = req_valid && !req_write;
  assign in_hdr      = req_addr[8:6] == 3'b000;
  assign in_ras      = req_addr[8:6] == 3'b001;
  assign in_hdm      = req_addr[8:7] == 2'b10;
  assign hdm_present = caps_q >= 3'd3;

  cmreg_hdr u_hdr (.caps(caps_q), .idx(req_addr[5:2]), .rdata(hdr_rd));

  cmreg_ras u_ras (
    .clk(clk), .rst(rst), .we(acc_wr && in_ras), .off(req_addr[5:2]),
    .wdata(req_wdata), .rdata(ras_rd));

  cmreg_hdm #(.NUM_DEC(NUM_DEC)) u_hdm (
    .clk(clk), .rst(rst), .present(hdm_present), .we(acc_wr && in_hdm),
    .off(req_addr[6:2]), .wdata(req_wdata), .rdata(hdm_rd));

  always_comb begin
    rd_mux = '0;
    if (legal) begin
      if (in_hdr)      rd_mux = hdr_rd;
      else if (in_ras) rd_mux = ras_rd;
      else if (in_hdm) rd_mux = hdm_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      caps_q    <= caps_of(comp_type);
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= is_rd;
      if (is_rd) rsp_rdata <= rd_mux;
    end
  end

  // R11: every read is answered in the next cycle
  p_rd_resp_r11: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> rsp_valid);
  // R11: writes give no response
  p_wr_no_resp_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rsp_valid);
  // R8: wide reads return zero
  p_wide_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (is_rd && req_size) |=> (rsp_rdata == '0));
  // R9: unaligned reads return zero
  p_unal_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (is_rd && req_addr[1:0] != 2'b00) |=> (rsp_rdata == '0));
  // R6: absent decoder block reads zero
  p_hdm_absent_r6: assert property (@(posedge clk) disable iff (rst)
    (is_rd && in_hdm && !hdm_present) |=> (rsp_rdata == '0));
  // R4: strap capture frozen outside reset
  p_strap_hold_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(caps_q));
endmodule

// File: tb/cmreg_bank_tb.sv
module cmreg_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  comp_type = 3'd0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmreg_bank u_dut (
    .clk(clk), .rst(rst), .comp_type(comp_type), .req_valid(req_valid),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] t);
    @(negedge clk);
    rst = 1'b1; comp_type = t;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic sz, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0; req_size = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd(a, 1'b0, d, v);
    check(tag, d, exp);
  endtask

  task automatic t_reset_state;
    do_reset(3'd0);
    check("R11 rsp_valid low after reset", {31'd0, rsp_valid}, 32'd0);
    expect_rd("R3 primary header type0", 9'h000, 32'h0211_0001);
    expect_rd("R5 RAS header", 9'h004, 32'h0402_0002);
    expect_rd("R5 link header", 9'h008, 32'h0802_0004);
    expect_rd("R5 entry beyond count", 9'h00C, 32'h0);
    expect_rd("R2 unc mask reset", 9'h044, 32'h0001_CFFF);
    expect_rd("R2 unc severity reset", 9'h048, 32'h0001_CFFF);
    expect_rd("R2 cor mask reset", 9'h050, 32'h0000_007F);
    expect_rd("R2 unc status reset", 9'h040, 32'h0);
    expect_rd("R2 cap ctrl reset", 9'h054, 32'h0);
  endtask

  task automatic t_masked_write;
    wr(9'h044, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R1 unc mask all ones", 9'h044, 32'h0001_CFFF);
    wr(9'h044, 32'hFFFF_0000, 1'b0);
    expect_rd("R1 unc mask upper half", 9'h044, 32'h0001_0000);
    wr(9'h048, 32'h0000_0000, 1'b0);
    expect_rd("R1 unc severity cleared", 9'h048, 32'h0);
    wr(9'h050, 32'hFFFF_FF80, 1'b0);
    expect_rd("R1 cor mask outside bits", 9'h050, 32'h0);
    wr(9'h040, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R1 RO status unchanged", 9'h040, 32'h0);
  endtask

  task automatic t_hdm_present;
    do_reset(3'd3);
    expect_rd("R4 type3 count", 9'h000, 32'h0311_0001);
    expect_rd("R5 HDM header", 9'h00C, 32'h1001_0005);
    expect_rd("R5 xsec absent", 9'h010, 32'h0);
    expect_rd("R6 HDM capability", 9'h100, 32'h0000_0310);
    wr(9'h100, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R1 HDM capability RO", 9'h100, 32'h0000_0310);
    wr(9'h104, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R6 global control mask", 9'h104, 32'h3);
    expect_rd("R7 base low reset", 9'h110, 32'h0);
    wr(9'h110, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R7 base low mask", 9'h110, 32'hF000_0000);
    wr(9'h114, 32'h1234_5678, 1'b0);
    expect_rd("R7 base high", 9'h114, 32'h1234_5678);
    wr(9'h118, 32'h5A5A_5A5A, 1'b0);
    expect_rd("R7 size low mask", 9'h118, 32'h5000_0000);
    wr(9'h11C, 32'hA5A5_A5A5, 1'b0);
    expect_rd("R7 size high", 9'h11C, 32'hA5A5_A5A5);
    wr(9'h120, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R7 control mask", 9'h120, 32'h0000_13FF);
  endtask

  task automatic t_root_port;
    do_reset(3'd5);
    expect_rd("R4 root count", 9'h000, 32'h0511_0001);
    expect_rd("R5 xsec header", 9'h010, 32'h1801_0006);
    expect_rd("R5 snoop header", 9'h014, 32'h1C01_0008);
    expect_rd("R5 beyond five", 9'h018, 32'h0);
    expect_rd("R7 control cleared by reset", 9'h120, 32'h0);
  endtask

  task automatic t_strap_codes;
    do_reset(3'd1); expect_rd("R4 code1", 9'h000, 32'h0211_0001);
    do_reset(3'd2); expect_rd("R4 code2", 9'h000, 32'h0311_0001);
    do_reset(3'd4); expect_rd("R4 code4", 9'h000, 32'h0311_0001);
    do_reset(3'd6); expect_rd("R4 code6", 9'h000, 32'h0211_0001);
    do_reset(3'd7); expect_rd("R4 code7", 9'h000, 32'h0211_0001);
    comp_type = 3'd5;
    @(negedge clk);
    expect_rd("R4 strap ignored after reset", 9'h000, 32'h0211_0001);
  endtask

  task automatic t_hdm_absent;
    do_reset(3'd0);
    wr(9'h104, 32'hFFFF_FFFF, 1'b0);
    wr(9'h114, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R6 absent cap zero", 9'h100, 32'h0);
    do_reset(3'd3);
    expect_rd("R6 absent write ignored gctl", 9'h104, 32'h0);
    expect_rd("R6 absent write ignored base", 9'h114, 32'h0);
  endtask

  task automatic t_illegal;
    logic [31:0] d; logic v;
    do_reset(3'd3);
    rd(9'h044, 1'b1, d, v);
    check("R8 wide read zero", d, 32'h0);
    check("R8 wide read answered", {31'd0, v}, 32'd1);
    wr(9'h044, 32'h0, 1'b1);
    expect_rd("R8 wide write dropped", 9'h044, 32'h0001_CFFF);
    rd(9'h046, 1'b0, d, v);
    check("R9 unaligned read zero", d, 32'h0);
    wr(9'h045, 32'h0, 1'b0);
    expect_rd("R9 unaligned write dropped", 9'h044, 32'h0001_CFFF);
    wr(9'h116, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R9 unaligned HDM write dropped", 9'h114, 32'h0);
    expect_rd("R10 unimplemented RAS gap", 9'h060, 32'h0);
    expect_rd("R10 link area", 9'h080, 32'h0);
    wr(9'h1F0, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R10 unimplemented high", 9'h1F0, 32'h0);
    wr(9'h124, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R10 gap after decoder", 9'h124, 32'h0);
  endtask

  task automatic t_handshake;
    logic [31:0] d; logic v;
    wr(9'h044, 32'h0000_0003, 1'b0);
    check("R11 no response to write", {31'd0, rsp_valid}, 32'd0);
    rd(9'h044, 1'b0, d, v);
    check("R11 read valid", {31'd0, v}, 32'd1);
    check("R11 read data", d, 32'h0000_0003);
    @(negedge clk);
    check("R11 valid one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset_vs_write;
    @(negedge clk);
    rst = 1'b1; comp_type = 3'd0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 9'h044; req_wdata = 32'h0; req_size = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rst = 1'b0;
    expect_rd("R12 reset wins over write", 9'h044, 32'h0001_CFFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_masked_write();
    t_hdm_present();
    t_root_port();
    t_strap_codes();
    t_hdm_absent();
    t_illegal();
    t_handshake();
    t_reset_vs_write();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule